// File: doc/BRIEF.md
# Get-Work Timeout Timer

This block bounds how long each processor slot waits on an outstanding request for new work. A slot opens a request with a start pulse and a wait flag. The request then closes in one of three ways. The search logic may report that it found work. The search may report that it has walked every queue and found nothing. Or a coarse timer may expire. The block answers each request with a one-cycle response pulse. A no-work flag travels with the pulse and tells the processor whether it received work.

The timeout period comes from a programmable field that counts in units of a fixed number of clocks, with n-1 encoding. A single free-running prescaler, shared by all slots, produces a tick once per period. A request expires on the second tick after it opens. The real delay therefore lies between one and two programmed periods, at the cost of one counter for the whole block. The wait flag decides whether a search that runs out of queues may end the request early, or whether only the timer can give a no-work answer. The queue search itself lies outside the block; its results arrive as per-slot inputs.

Top module: `getwork_timeout`

## Requirements
- R1: The period field P (reset value 0) sets a prescaler period of L = (P+1)*UNIT_CYCLES clocks. A write to the field restarts the prescaler phase, so ticks fall on the edges L, 2L, 3L, ... after the write edge. A write made while a request is open does not discard a tick that request has already counted.
- R2: While reset is active and after reset is released, no response pulse is issued until some request ends.
- R3: A request that receives neither outcome ends on the second prescaler tick after its start edge. A tick on the start edge itself does not count. The response rises between L+1 and 2L edges after the start edge, with the no-work flag set to 1.
- R4: A found-work indication on an open slot ends the request on that edge, with a response and the no-work flag at 0, for either value of the wait flag.
- R5: With the wait flag 0, a search-exhausted indication on an open slot ends the request on that edge, with the no-work flag at 1.
- R6: With the wait flag 1, a search-exhausted indication has no effect, and the request runs on to timer expiry.
- R7: Found-work wins over timer expiry and over search-exhausted in the same cycle, and the no-work flag is then 0.
- R8: A start pulse on a slot that already has an open request is ignored. The expiry time and the wait flag latched at the first start are kept.
- R9: Found-work and search-exhausted indications on an idle slot produce no response.
- R10: Each response is a single-cycle pulse. Slots are independent: an outcome on one slot never produces a response on another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| periodWrEn | input | 1 | Write strobe for the period field |
| periodWrData | input | PERIOD_W | New period value in n-1 encoding |
| reqStart | input | NUM_SLOTS | Per-slot request start pulse |
| reqWait | input | NUM_SLOTS | Per-slot wait flag, sampled with the start pulse |
| foundWork | input | NUM_SLOTS | Per-slot search found executable work |
| searchDone | input | NUM_SLOTS | Per-slot search reached the end of all queues |
| rspValid | output | NUM_SLOTS | Per-slot single-cycle response pulse |
| rspNoWork | output | NUM_SLOTS | Per-slot no-work flag, valid with rspValid |

## Verification
A slot whose tick count is wrong shows up as a response one whole period early or late. The bench sweeps every prescaler phase at every start offset and every period value for a small unit, so such an error is caught on the edge where the response should rise. A corrupted latched wait flag or a missed busy state shows on the first search-exhausted or repeated start pulse: a response appears on that edge, or stays away until expiry. A broken prescaler phase after a write shows as an expiry edge that is offset within the next 2L cycles.

// File: rtl/nwt_pkg.sv
package nwt_pkg;

  // Life of one slot's request: idle, open with no tick seen, open with one tick seen
  typedef enum logic [1:0] {
    SLOT_IDLE   = 2'd0,
    SLOT_ARMED  = 2'd1,
    SLOT_PRIMED = 2'd2
  } slotState_e;

  // Per-slot strobe from control to the response registers
  typedef struct packed {
    logic fire;
    logic noWork;
  } slotStb_t;

  // Strobe from control to the prescaler
  typedef struct packed {
    logic loadPeriod;
  } prescStb_t;

endpackage

// File: rtl/nwt_slot.sv
module nwt_slot
  import nwt_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick,
  input  logic     start,
  input  logic     waitIn,
  input  logic     found,
  input  logic     exhausted,
  output slotStb_t strobe
);

  slotState_e st, stNext;
  logic       waitQ;

  always_comb begin
    stNext = st;
    strobe = '0;
    case (st)
      SLOT_IDLE: begin
        if (start) stNext = SLOT_ARMED;
      end
      default: begin
        if (found) begin
          strobe.fire = 1'b1;
          stNext      = SLOT_IDLE;
        end else if (exhausted && !waitQ) begin
          strobe.fire   = 1'b1;
          strobe.noWork = 1'b1;
          stNext        = SLOT_IDLE;
        end else if (tick) begin
          if (st == SLOT_PRIMED) begin
            strobe.fire   = 1'b1;
            strobe.noWork = 1'b1;
            stNext        = SLOT_IDLE;
          end else begin
            stNext = SLOT_PRIMED;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= SLOT_IDLE;
      waitQ <= 1'b0;
    end else begin
      st <= stNext;
      if (st == SLOT_IDLE && start) waitQ <= waitIn;
    end
  end

  // R4: found work always closes an open request
  a_r4_found_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (st != SLOT_IDLE && found) |=> (st == SLOT_IDLE));

  // R6: with the wait flag set, exhaustion alone keeps the request open
  a_r6_wait_ignores_done: assert property (@(posedge clk) disable iff (!rst_n)
    (st != SLOT_IDLE && waitQ && exhausted && !found && !tick) |=> (st != SLOT_IDLE));

  // R8: an open request keeps its latched wait flag through extra starts
  a_r8_busy_keeps_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (st != SLOT_IDLE && start) |=> $stable(waitQ));

  // R3: a second tick with no found work ends the request
  a_r3_second_tick_expires: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SLOT_PRIMED && tick && !found) |=> (st == SLOT_IDLE));

endmodule

// File: rtl/nwt_control.sv
module nwt_control
  import nwt_pkg::*;
#(
  parameter int NUM_SLOTS = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           periodWrEn,
  input  logic                           tick,
  input  logic [NUM_SLOTS-1:0]           reqStart,
  input  logic [NUM_SLOTS-1:0]           reqWait,
  input  logic [NUM_SLOTS-1:0]           foundWork,
  input  logic [NUM_SLOTS-1:0]           searchDone,
  output prescStb_t                      presc,
  output slotStb_t [NUM_SLOTS-1:0]       slotStb
);

  assign presc.loadPeriod = periodWrEn;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    nwt_slot u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .start     (reqStart[g]),
      .waitIn    (reqWait[g]),
      .found     (foundWork[g]),
      .exhausted (searchDone[g]),
      .strobe    (slotStb[g])
    );
  end

endmodule

// File: rtl/nwt_datapath.sv
module nwt_datapath
  import nwt_pkg::*;
#(
  parameter int NUM_SLOTS   = 16,
  parameter int PERIOD_W    = 10,
  parameter int UNIT_CYCLES = 1024
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  prescStb_t                presc,
  input  logic [PERIOD_W-1:0]      periodWrData,
  input  slotStb_t [NUM_SLOTS-1:0] slotStb,
  output logic                     tick,
  output logic [NUM_SLOTS-1:0]     rspValid,
  output logic [NUM_SLOTS-1:0]     rspNoWork
);

  localparam int UNIT_W = (UNIT_CYCLES > 1) ? $clog2(UNIT_CYCLES) : 1;
  localparam logic [UNIT_W-1:0] UNIT_LAST = UNIT_W'(UNIT_CYCLES - 1);

  logic [PERIOD_W-1:0] periodQ;
  logic [PERIOD_W-1:0] periodCnt;
  logic [UNIT_W-1:0]   unitCnt;
  logic                unitWrap;

  assign unitWrap = (unitCnt == UNIT_LAST);
  assign tick     = unitWrap && (periodCnt == periodQ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      periodQ   <= '0;
      periodCnt <= '0;
      unitCnt   <= '0;
    end else if (presc.loadPeriod) begin
      periodQ   <= periodWrData;
      periodCnt <= '0;
      unitCnt   <= '0;
    end else if (unitWrap) begin
      unitCnt   <= '0;
      periodCnt <= (periodCnt == periodQ) ? '0 : periodCnt + 1'b1;
    end else begin
      unitCnt   <= unitCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rspValid  <= '0;
      rspNoWork <= '0;
    end else begin
      for (int i = 0; i < NUM_SLOTS; i++) begin
        rspValid[i]  <= slotStb[i].fire;
        rspNoWork[i] <= slotStb[i].fire & slotStb[i].noWork;
      end
    end
  end

  // R1: ticks are never adjacent without a period write in between
  if (UNIT_CYCLES > 1) begin : g_tick_chk
    a_r1_tick_isolated: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !presc.loadPeriod) |=> !tick);
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_rsp_chk
    // R10: a response lasts one cycle
    a_r10_resp_single: assert property (@(posedge clk) disable iff (!rst_n)
      rspValid[g] |=> !rspValid[g]);
    // R4: the flag seen at the port follows the control decision
    a_r4_flag_follows: assert property (@(posedge clk) disable iff (!rst_n)
      slotStb[g].fire |=> (rspValid[g] && (rspNoWork[g] == $past(slotStb[g].noWork))));
  end

endmodule

// File: rtl/getwork_timeout.sv
module getwork_timeout
  import nwt_pkg::*;
#(
  parameter int NUM_SLOTS   = 16,
  parameter int PERIOD_W    = 10,
  parameter int UNIT_CYCLES = 1024
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 periodWrEn,
  input  logic [PERIOD_W-1:0]  periodWrData,
  input  logic [NUM_SLOTS-1:0] reqStart,
  input  logic [NUM_SLOTS-1:0] reqWait,
  input  logic [NUM_SLOTS-1:0] foundWork,
  input  logic [NUM_SLOTS-1:0] searchDone,
  output logic [NUM_SLOTS-1:0] rspValid,
  output logic [NUM_SLOTS-1:0] rspNoWork
);

  prescStb_t                presc;
  slotStb_t [NUM_SLOTS-1:0] slotStb;
  logic                     tick;

  nwt_control #(
    .NUM_SLOTS (NUM_SLOTS)
  ) u_control (
    .clk        (clk),
    .rst_n      (rst_n),
    .periodWrEn (periodWrEn),
    .tick       (tick),
    .reqStart   (reqStart),
    .reqWait    (reqWait),
    .foundWork  (foundWork),
    .searchDone (searchDone),
    .presc      (presc),
    .slotStb    (slotStb)
  );

  nwt_datapath #(
    .NUM_SLOTS   (NUM_SLOTS),
    .PERIOD_W    (PERIOD_W),
    .UNIT_CYCLES (UNIT_CYCLES)
  ) u_datapath (
    .clk          (clk),
    .rst_n        (rst_n),
    .presc        (presc),
    .periodWrData (periodWrData),
    .slotStb      (slotStb),
    .tick         (tick),
    .rspValid     (rspValid),
    .rspNoWork    (rspNoWork)
  );

endmodule

// File: tb/getwork_timeout_tb.sv
module getwork_timeout_tb;

  localparam int SLOTS = 2;
  localparam int PW    = 3;
  localparam int UNIT  = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             periodWrEn = 1'b0;
  logic [PW-1:0]    periodWrData = '0;
  logic [SLOTS-1:0] reqStart = '0;
  logic [SLOTS-1:0] reqWait = '0;
  logic [SLOTS-1:0] foundWork = '0;
  logic [SLOTS-1:0] searchDone = '0;
  logic [SLOTS-1:0] rspValid;
  logic [SLOTS-1:0] rspNoWork;

  getwork_timeout #(
    .NUM_SLOTS   (SLOTS),
    .PERIOD_W    (PW),
    .UNIT_CYCLES (UNIT)
  ) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .periodWrEn   (periodWrEn),
    .periodWrData (periodWrData),
    .reqStart     (reqStart),
    .reqWait      (reqWait),
    .foundWork    (foundWork),
    .searchDone   (searchDone),
    .rspValid     (rspValid),
    .rspNoWork    (rspNoWork)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks   = 0;
  int failures = 0;
  bit finished = 1'b0;
  int lastWr   = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic writePeriod(int p);
    periodWrEn   = 1'b1;
    periodWrData = PW'(p);
    @(negedge clk);
    periodWrEn = 1'b0;
    lastWr     = cyc;
  endtask

  task automatic startReq(int s, bit w, output int edgeOut);
    reqStart[s] = 1'b1;
    reqWait[s]  = w;
    @(negedge clk);
    reqStart[s] = 1'b0;
    reqWait[s]  = 1'b0;
    edgeOut     = cyc;
  endtask

  task automatic pulseIn(int s, bit f, bit d, output int edgeOut);
    foundWork[s]  = f;
    searchDone[s] = d;
    @(negedge clk);
    foundWork[s]  = 1'b0;
    searchDone[s] = 1'b0;
    edgeOut       = cyc;
  endtask

  task automatic waitResp(int s, int limit, output int e, output bit nw);
    e  = -1;
    nw = 1'b0;
    for (int i = 0; i < limit; i++) begin
      if (rspValid[s]) begin
        e  = cyc;
        nw = rspNoWork[s];
        break;
      end
      @(negedge clk);
    end
    if (e >= 0) begin
      @(negedge clk);
      chk(!rspValid[s], "R10 pulse width", int'(rspValid[s]), 0);
    end
  endtask

  task automatic quiet(int s, int n, string req);
    bit seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (rspValid[s]) seen = 1'b1;
      @(negedge clk);
    end
    chk(!seen, req, int'(seen), 0);
  endtask

  function automatic int expiryEdge(int w, int len, int s);
    int m1 = (s - w) / len + 1;
    return w + (m1 + 1) * len;
  endfunction

  initial begin
    int s, s2, e, f, x, expE, len, t1, w2;
    bit nw;
    repeat (3) @(negedge clk);
    chk(rspValid == '0, "R2 during reset", int'(rspValid), 0);
    rst_n = 1'b1;
    quiet(0, 3, "R2 after reset slot0");
    chk(rspValid[1] == 1'b0, "R2 after reset slot1", int'(rspValid[1]), 0);

    // R1: reset period value 0 gives L = UNIT
    startReq(0, 1'b1, s);
    waitResp(0, 20, e, nw);
    chk((e >= s + UNIT + 1) && (e <= s + 2 * UNIT), "R1 reset period window", e - s, 2 * UNIT);

    // R1/R3: every period value and every start phase
    for (int p = 0; p < (1 << PW); p++) begin
      writePeriod(p);
      len = (p + 1) * UNIT;
      for (int ph = 0; ph < len; ph++) begin
        while (((cyc + 1 - lastWr) % len) != ph) @(negedge clk);
        startReq(0, bit'(ph & 1), s);
        expE = expiryEdge(lastWr, len, s);
        waitResp(0, 3 * len, e, nw);
        chk(e == expE, "R3 expiry edge", e, expE);
        chk(nw == 1'b1, "R3 expiry no-work flag", int'(nw), 1);
      end
    end

    writePeriod(1);
    len = 2 * UNIT;

    // R4: found work, both wait values
    for (int w = 0; w < 2; w++) begin
      startReq(0, bit'(w), s);
      @(negedge clk);
      pulseIn(0, 1'b1, 1'b0, f);
      waitResp(0, 4, e, nw);
      chk(e == f, "R4 found edge", e, f);
      chk(nw == 1'b0, "R4 found flag", int'(nw), 0);
    end

    // R5: exhausted with wait clear
    startReq(0, 1'b0, s);
    @(negedge clk);
    pulseIn(0, 1'b0, 1'b1, f);
    waitResp(0, 4, e, nw);
    chk(e == f, "R5 exhausted edge", e, f);
    chk(nw == 1'b1, "R5 exhausted flag", int'(nw), 1);

    // R6: exhausted with wait set is ignored
    startReq(0, 1'b1, s);
    pulseIn(0, 1'b0, 1'b1, x);
    chk(!rspValid[0], "R6 exhausted ignored", int'(rspValid[0]), 0);
    expE = expiryEdge(lastWr, len, s);
    waitResp(0, 5 * len, e, nw);
    chk(e == expE, "R6 runs to expiry", e, expE);
    chk(nw == 1'b1, "R6 expiry flag", int'(nw), 1);

    // R7: found, exhausted and expiry on the same edge
    startReq(0, 1'b0, s);
    expE = expiryEdge(lastWr, len, s);
    while (cyc != expE - 1) @(negedge clk);
    pulseIn(0, 1'b1, 1'b1, f);
    waitResp(0, 4, e, nw);
    chk(e == expE, "R7 priority edge", e, expE);
    chk(nw == 1'b0, "R7 found wins", int'(nw), 0);

    // R8: second start ignored, first wait flag kept
    startReq(0, 1'b1, s);
    @(negedge clk);
    @(negedge clk);
    startReq(0, 1'b0, s2);
    pulseIn(0, 1'b0, 1'b1, x);
    chk(!rspValid[0], "R8 wait flag kept", int'(rspValid[0]), 0);
    expE = expiryEdge(lastWr, len, s);
    waitResp(0, 5 * len, e, nw);
    chk(e == expE, "R8 expiry from first start", e, expE);

    // R9: outcomes on an idle slot
    pulseIn(0, 1'b1, 1'b1, x);
    quiet(0, 4, "R9 idle found ignored");
    pulseIn(1, 1'b0, 1'b1, x);
    quiet(1, 4, "R9 idle exhausted ignored");

    // R10: slot independence
    startReq(1, 1'b1, s2);
    startReq(0, 1'b1, s);
    pulseIn(0, 1'b1, 1'b0, f);
    chk(!rspValid[1], "R10 other slot quiet", int'(rspValid[1]), 0);
    waitResp(0, 4, e, nw);
    chk(e == f, "R10 slot0 found edge", e, f);
    expE = expiryEdge(lastWr, len, s2);
    waitResp(1, 5 * len, e, nw);
    chk(e == expE, "R10 slot1 expiry edge", e, expE);

    // R1: period write in the middle of a request
    writePeriod(1);
    startReq(0, 1'b1, s);
    t1 = lastWr + ((s - lastWr) / len + 1) * len;
    while (cyc != t1 + 1) @(negedge clk);
    writePeriod(3);
    w2 = lastWr;
    expE = w2 + 4 * UNIT;
    waitResp(0, 10 * len, e, nw);
    chk(e == expE, "R1 write restarts phase", e, expE);
    chk(nw == 1'b1, "R1 write expiry flag", int'(nw), 1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog all-requirements actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule